// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block is the first register map that firmware sees at the CPU hotplug address window. It holds one presence bit per CPU slot. The bit position is the CPU's interrupt-controller ID. The host reads the map one byte at a time. Ordinary stores into the map change nothing. Slot 0 is the boot processor, so its bit always reads as one.

A hot-add request arrives on a valid/ready stream that carries the slot ID. When the request is accepted, the block marks that slot present and latches general-purpose event flag 2. While any event flag is latched, the system control interrupt is raised. Firmware clears the flag with a separate acknowledge strobe. A store of zero into all four byte lanes of the first 32-bit word switches the window to the modern register map. After that switch, a mode flag tells a companion block to take over the window. This block then answers reads with zero, ignores stores and holds off further hot-add requests. It stays in this state until reset.

Back-pressure rule on the hot-add stream: `add_ready` is high in legacy mode and low in modern mode. A request transfers only on a cycle where both `add_valid` and `add_ready` are high. A held request stays pending and has no effect while `add_ready` is low.

Top module: `cpu_presence_port`

## Requirements
- R1: After reset the map reads 0x01 at byte 0 and 0x00 elsewhere. The outputs `sci`, `gpe_sts` and `modern_mode` are 0, and `add_ready` is 1.
- R2: An accepted hot-add with ID n sets bit n%8 of byte n/8, and the bit stays set until reset.
- R3: Bit 0 of byte 0 reads as 1 in legacy mode, even after a zero is written to that byte.
- R4: Bus writes never change the map contents.
- R5: An accepted in-range hot-add sets `gpe_sts` bit 2, so `gpe_sts` reads 0x04 and `sci` is 1, from the cycle after the transfer.
- R6: `evt_ack` clears `gpe_sts` and `sci` on the next cycle. If an accepted in-range hot-add arrives in the same cycle, the flag stays set.
- R7: `modern_mode` rises on the cycle after the last of four zero-data writes that cover byte addresses 0 to 3. A nonzero write to any of those addresses cancels all earlier zero lanes. Writes to addresses 4 and above do not count.
- R8: Once set, `modern_mode` stays 1 until reset. While it is set, reads return 0x00 and writes are ignored.
- R9: `add_ready` equals 0 in modern mode. A request held there does not set `sci`.
- R10: A hot-add with an ID of 64 or more (`NUM_SLOTS` or more) is accepted and dropped. It sets no bit and does not raise `sci`.
- R11: Every read strobe gives `bus_rvalid` on the next cycle with the addressed byte. Addresses 8 to 31, which lie past the map, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Byte read strobe |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| bus_rdata | output | 8 | Read data |
| add_valid | input | 1 | Hot-add request valid |
| add_id | input | 8 | Interrupt-controller ID of the added CPU |
| add_ready | output | 1 | Hot-add request accepted |
| evt_ack | input | 1 | Clears the latched event flags |
| gpe_sts | output | 8 | General-purpose event flags (bit 2 = CPU hotplug) |
| sci | output | 1 | System control interrupt request |
| modern_mode | output | 1 | Window handed to the modern register map |

## Verification
Two cases can fall in the same cycle: a hot-add that sets event flag 2 and an `evt_ack` strobe that clears it. The bench drives both inputs on one clock edge and expects `sci` to remain high. A second, lone acknowledge must then drop it. The bench also sends an out-of-range ID together with an acknowledge and expects the flag to clear, because a dropped request must not count as a set. A hot-add that lands in the same cycle as the final zero lane of the mode switch is still accepted: `add_ready` only falls after the switch has been recorded, and the bench confirms that the new bit is kept after the switch.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned WORD0_LANES = 4;
  typedef enum logic {
    MAP_LEGACY = 1'b0,
    MAP_MODERN = 1'b1
  } map_mode_e;
endpackage

// File: rtl/cpb_present_map.sv
module cpb_present_map #(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned ID_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add_fire,
  input  logic [ID_W-1:0]      add_id,
  output logic                 add_hit,
  output logic [NUM_SLOTS-1:0] present_q
);
  localparam logic [ID_W:0] SLOT_LIMIT = (ID_W+1)'(NUM_SLOTS);

  assign add_hit = add_fire && ({1'b0, add_id} < SLOT_LIMIT);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_boot
      assign present_q[g] = 1'b1;
    end else begin : g_hot
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                 bit_q <= 1'b0;
        else if (add_hit && add_id == ID_W'(g))     bit_q <= 1'b1;
      end
      assign present_q[g] = bit_q;
    end
  end

  // R2: slots never leave the map (no removal path)
  a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (present_q & $past(present_q)) == $past(present_q));
  // R10: out-of-range IDs leave the map untouched
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (add_fire && !add_hit) |=> (present_q == $past(present_q)));
endmodule

// File: rtl/cpb_mode_switch.sv
module cpb_mode_switch
  import cpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             bus_wdata,
  output map_mode_e         mode_q
);
  localparam int unsigned LANE_W = $clog2(WORD0_LANES);
  localparam logic [ADDR_W-1:0] LANE_LIMIT = ADDR_W'(WORD0_LANES);

  logic [WORD0_LANES-1:0] zero_lanes_q, zero_lanes_d;
  logic word0_wr;

  assign word0_wr = bus_wr && (mode_q == MAP_LEGACY) && (bus_addr < LANE_LIMIT);

  always_comb begin
    zero_lanes_d = zero_lanes_q;
    if (word0_wr) begin
      if (bus_wdata == 8'h00) zero_lanes_d[bus_addr[LANE_W-1:0]] = 1'b1;
      else                    zero_lanes_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_lanes_q <= '0;
      mode_q       <= MAP_LEGACY;
    end else begin
      zero_lanes_q <= zero_lanes_d;
      if (&zero_lanes_d) mode_q <= MAP_MODERN;
    end
  end

  // R8: the hand-over is permanent until reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_MODERN) |=> (mode_q == MAP_MODERN));
  // R7: the switch follows a zero write into word 0
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_LEGACY) ##1 (mode_q == MAP_MODERN) |->
      $past(bus_wr && bus_wdata == 8'h00 && bus_addr < LANE_LIMIT));
endmodule

// File: rtl/cpb_event_flag.sv
module cpb_event_flag #(
  parameter int unsigned GPE_W   = 8,
  parameter int unsigned EVT_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_set,
  input  logic             evt_ack,
  output logic [GPE_W-1:0] gpe_q,
  output logic             sci
);
  for (genvar b = 0; b < GPE_W; b++) begin : g_flag
    if (b == EVT_BIT) begin : g_live
      logic f_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       f_q <= 1'b0;
        else if (evt_set) f_q <= 1'b1;
        else if (evt_ack) f_q <= 1'b0;
      end
      assign gpe_q[b] = f_q;
    end else begin : g_idle
      assign gpe_q[b] = 1'b0;
    end
  end

  assign sci = |gpe_q;

  // R6: a set in the acknowledge cycle wins
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> sci);
  // R6: a lone acknowledge drops the request
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ack && !evt_set) |=> !sci);
endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port
  import cpb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned GPE_W     = 8,
  parameter int unsigned EVT_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              bus_rvalid,
  output logic [7:0]        bus_rdata,
  input  logic              add_valid,
  input  logic [ID_W-1:0]   add_id,
  output logic              add_ready,
  input  logic              evt_ack,
  output logic [GPE_W-1:0]  gpe_sts,
  output logic              sci,
  output logic              modern_mode
);
  localparam int unsigned NUM_BYTES = NUM_SLOTS / 8;
  localparam int unsigned BIDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [ADDR_W:0] BYTE_LIMIT = (ADDR_W+1)'(NUM_BYTES);

  map_mode_e            mode_q;
  logic [NUM_SLOTS-1:0] present_q;
  logic                 add_fire, add_hit;
  byte_t                map_bytes [NUM_BYTES];
  byte_t                rdata_d;

  assign modern_mode = (mode_q == MAP_MODERN);
  assign add_ready   = !modern_mode;
  assign add_fire    = add_valid && add_ready;

  cpb_present_map #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_map (
    .clk(clk), .rst_n(rst_n), .add_fire(add_fire), .add_id(add_id),
    .add_hit(add_hit), .present_q(present_q)
  );

  cpb_mode_switch #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_q(mode_q)
  );

  cpb_event_flag #(.GPE_W(GPE_W), .EVT_BIT(EVT_BIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_set(add_hit), .evt_ack(evt_ack),
    .gpe_q(gpe_sts), .sci(sci)
  );

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    assign map_bytes[k] = present_q[k*8 +: 8];
  end

  always_comb begin
    rdata_d = 8'h00;
    if (!modern_mode && ({1'b0, bus_addr} < BYTE_LIMIT))
      rdata_d = map_bytes[bus_addr[BIDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rdata_d : 8'h00;
    end
  end

  // R11: one response per read strobe, next cycle
  a_r11_resp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R8: the handed-over window answers zero
  a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && modern_mode) |=> (bus_rdata == 8'h00));
  // R3: boot slot visible on byte 0 in legacy mode
  a_r3_boot_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !modern_mode && bus_addr == '0) |=> bus_rdata[0]);
  // R5: an accepted in-range request raises the interrupt
  a_r5_sci: assert property (@(posedge clk) disable iff (!rst_n)
    add_hit |=> (sci && gpe_sts[EVT_BIT]));
endmodule

// File: tb/sim_cpu_presence_port.sv
`timescale 1ns/1ps
module sim_cpu_presence_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rvalid;
  logic [7:0] bus_rdata;
  logic       add_valid = 0;
  logic [7:0] add_id = '0;
  logic       add_ready;
  logic       evt_ack = 0;
  logic [7:0] gpe_sts;
  logic       sci, modern_mode;

  int total = 0, bad = 0;
  logic [63:0] mdl = 64'h1;
  bit          mdl_modern = 0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  cpu_presence_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .add_valid(add_valid), .add_id(add_id),
    .add_ready(add_ready), .evt_ack(evt_ack), .gpe_sts(gpe_sts),
    .sci(sci), .modern_mode(modern_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    if (mdl_modern || a >= 8) return 8'h00;
    return mdl[a*8 +: 8];
  endfunction

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected response", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = 5'(a);
    exp_q.push_back(exp_byte(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 32; a++) rd(a, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic hot(input int id, input bit ack);
    @(negedge clk);
    add_valid = 1; add_id = 8'(id); evt_ack = ack;
    @(negedge clk);
    add_valid = 0; evt_ack = 0;
    if (id < 64 && !mdl_modern) mdl[id] = 1'b1;
  endtask

  task automatic ack_only();
    @(negedge clk); evt_ack = 1;
    @(negedge clk); evt_ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mdl = 64'h1; mdl_modern = 0;
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sci == 0 && gpe_sts == 0, "R1 sci/gpe at reset", {gpe_sts, 7'd0, sci}, 0);
    chk(modern_mode == 0, "R1 mode at reset", modern_mode, 0);
    chk(add_ready == 1, "R1 ready at reset", add_ready, 1);
    rd_all("R1/R11 reset map");

    hot(9, 0);
    chk(sci == 1, "R5 sci after hot-add", sci, 1);
    chk(gpe_sts == 8'h04, "R5 gpe flag 2", gpe_sts, 8'h04);
    rd(1, "R2 id 9 -> byte 1 bit 1");
    ack_only();
    chk(sci == 0, "R6 ack clears sci", sci, 0);

    hot(63, 1);
    chk(sci == 1, "R6 set wins over ack", sci, 1);
    ack_only();
    chk(sci == 0, "R6 lone ack", sci, 0);

    hot(100, 0);
    chk(sci == 0, "R10 out-of-range no sci", sci, 0);
    hot(64, 0);
    chk(gpe_sts == 0, "R10 id 64 no flag", gpe_sts, 0);
    hot(200, 1);
    chk(sci == 0, "R6 dropped id does not win over ack", sci, 0);
    hot(20, 0); hot(37, 0); ack_only();
    rd_all("R2/R10 map after adds");

    wr(8, 8'hFF); wr(5, 8'hA5); wr(2, 8'h3C); wr(0, 8'h00);
    rd_all("R4/R3 map after writes");
    chk(modern_mode == 0, "R7 partial zero lanes", modern_mode, 0);

    wr(0, 0); wr(1, 0); wr(2, 0); wr(4, 0); wr(3, 8'h5A);
    chk(modern_mode == 0, "R7 nonzero lane cancels", modern_mode, 0);
    wr(3, 0); wr(0, 0); wr(1, 0);
    chk(modern_mode == 0, "R7 three lanes only", modern_mode, 0);
    // last lane together with a hot-add in the same cycle
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'd2; bus_wdata = 8'h00;
    add_valid = 1; add_id = 8'd44;
    @(negedge clk);
    bus_wr = 0; add_valid = 0;
    mdl[44] = 1'b1;
    chk(modern_mode == 1, "R7 fourth zero lane switches", modern_mode, 1);
    chk(add_ready == 0, "R9 ready low in modern mode", add_ready, 0);
    chk(sci == 1, "R5 add in switch cycle accepted", sci, 1);
    ack_only();
    mdl_modern = 1;

    @(negedge clk); add_valid = 1; add_id = 8'd12;
    repeat (4) @(negedge clk);
    chk(sci == 0, "R9 held request ignored", sci, 0);
    add_valid = 0;
    wr(0, 8'h11);
    rd_all("R8 modern reads zero");
    repeat (20) @(negedge clk);
    chk(modern_mode == 1, "R8 mode sticky", modern_mode, 1);

    do_reset();
    @(negedge clk);
    chk(modern_mode == 0, "R8 reset leaves modern", modern_mode, 0);
    rd_all("R1 map after second reset");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule